// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Queue

This block turns an asynchronous serial line into characters. It samples the line with a 16x tick, checks parity and the stop bit, and detects line breaks. Each character goes into an eight-entry queue together with its own break, framing and parity flags. The CPU side sees the character at the head of the queue on `rd_data` and removes it by pulsing `rd_en`. A status byte reports the error flags, a sticky overrun flag, queue-full and receiver-ready.

When the queue is full, one more completed character can wait in a holding slot. Any further character is dropped and raises overrun. Error flags are reported in one of two ways, chosen by `blk_mode`:
- In per-character mode, the status shows the flags of the head entry.
- In block mode, the flags of every entry are ORed into a sticky set as the entry is stored.

Two commands act on the block. `cmd_err_clr` clears the error flags. `cmd_rx_reset` returns the whole receiver to its reset state.

Top module: `rxq_uart_rx`

## Requirements
- R1: After reset `status` reads 0x00. Its bits are: 7 break, 6 framing error, 5 parity error, 4 overrun, 3..2 always zero, 1 queue full, 0 receiver ready.
- R2: Data bits arrive least significant bit first. The character length is 5 + `char_len` bits (0 to 3 gives 5 to 8 bits). Unused upper bits of `rd_data` are zero. `rd_data` shows the head entry, or zero when the queue is empty.
- R3: A falling edge starts a character only if the line is still low at the 8th tick after it. Otherwise nothing is received.
- R4: Each entry stores its own flags. Framing error means the stop bit sampled at its middle was low. Parity error applies when `par_en`=1 and the parity is wrong (`par_odd`=1 selects odd, 0 selects even). With `blk_mode`=0, status bits 7:5 show the head entry's flags, and those flags vanish when the entry is read.
- R5: With `blk_mode`=1, status bits 7:5 are the OR of the flags of all entries stored since the last clear. Reads do not clear them. Only `cmd_err_clr` or `cmd_rx_reset` does.
- R6: Receiver-ready is set when a character enters the queue. It clears only when a read leaves the queue empty.
- R7: Queue-full is set when an entry fills all eight slots. A read clears it, unless a character is waiting in the holding slot, in which case it stays set.
- R8: A character that completes while the queue is full and the holding slot is occupied is lost, and it sets overrun. Only `cmd_err_clr` or `cmd_rx_reset` clears overrun.
- R9: A held character enters the queue in the cycle after a read. It enters at the tail, so characters are read back in arrival order.
- R10: A break is an all-zero character, including its parity bit, with a low stop bit. It stores one entry with data 0x00 and only the break flag set. Nothing more is stored until the line has been high for 8 ticks. `brk_change` pulses for one cycle when the break is found and again when it ends.
- R11: `cmd_rx_reset` empties the queue and the holding slot and clears every flag. Reception then resumes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sampling enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| blk_mode | input | 1 | 1 = accumulate error flags |
| cmd_err_clr | input | 1 | Clear error flags and overrun |
| cmd_rx_reset | input | 1 | Reset receiver and discard queue |
| rd_en | input | 1 | Consume head entry |
| rd_data | output | 8 | Head entry data |
| status | output | 8 | Status byte |
| brk_change | output | 1 | Pulse at break start and end |

## Verification
The bench goes after the following corner cases:
- **Ten characters into a full queue.** This exercises the holding slot and overrun together. A design that dropped the held character, or kept the tenth one, returns the wrong sequence. A design that cleared queue-full on the first read shows bit 1 low while a character is still waiting.
- **A short low glitch.** A design without start validation would store a spurious character here.
- **A long break.** A design that stored one entry per character time fills the queue with zeros instead of storing one break entry.
- **Switching between the two error modes.** A design that mixed them up shows head-only flags where sticky flags are required.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [RXQ_DW-1:0] data;
  } rx_char_t;

  localparam int RXQ_EW = $bits(rx_char_t);
endpackage

// File: rtl/rxq_deser.sv
module rxq_deser
  import rxq_pkg::*;
#(
  parameter int TICKS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic [1:0] char_len,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     done,
  output rx_char_t chr,
  output logic     brk_edge
);
  localparam int CW = $clog2(TICKS);
  localparam int BW = $clog2(RXQ_DW);
  localparam logic [CW-1:0] HALF = CW'(TICKS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK} st_t;
  st_t st;

  logic [CW-1:0]     cnt, hicnt;
  logic [BW-1:0]     bidx;
  logic [RXQ_DW-1:0] sh;
  logic              pbit;
  logic [BW:0]       nbits;
  logic              zero_char, perr;

  assign nbits     = (BW+1)'(5) + (BW+1)'(char_len);
  assign zero_char = (sh == '0) && (!par_en || !pbit);
  assign perr      = par_en && ((^{sh, pbit}) != par_odd);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; hicnt <= '0; bidx <= '0; sh <= '0; pbit <= 1'b0;
      done <= 1'b0; brk_edge <= 1'b0; chr <= '0;
    end else begin
      done     <= 1'b0;
      brk_edge <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (!rxd_s) begin st <= ST_START; cnt <= '0; end
          ST_START: begin
            if (cnt == HALF) begin
              if (!rxd_s) begin st <= ST_DATA; cnt <= '0; bidx <= '0; sh <= '0; end
              else st <= ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt <= '0;
              sh[bidx] <= rxd_s;
              if ({1'b0, bidx} == nbits - 1'b1) st <= par_en ? ST_PAR : ST_STOP;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == LAST) begin cnt <= '0; pbit <= rxd_s; st <= ST_STOP; end
            else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              done <= 1'b1;
              if (!rxd_s && zero_char) begin
                chr      <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: '0};
                brk_edge <= 1'b1;
                hicnt    <= '0;
                st       <= ST_BRK;
              end else begin
                chr <= '{brk: 1'b0, fe: !rxd_s, pe: perr, data: sh};
                st  <= ST_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_BRK: begin
            if (rxd_s) begin
              if (hicnt == HALF) begin st <= ST_IDLE; brk_edge <= 1'b1; end
              else hicnt <= hicnt + 1'b1;
            end else hicnt <= '0;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  brk_pulse_chk: assert property (@(posedge clk) disable iff (rst) brk_edge |=> !brk_edge);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 11,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic            full,
  output logic            empty,
  output logic [CNTW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  assign head  = mem[rptr];
  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R6
  pop_data_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/rxq_uart_rx.sv
module rxq_uart_rx
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TICKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       blk_mode,
  input  logic       cmd_err_clr,
  input  logic       cmd_rx_reset,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  output logic       brk_change
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic rx_meta, rx_sync, rx_soft;
  assign rx_soft = rst | cmd_rx_reset;

  always_ff @(posedge clk) begin
    if (rst) begin rx_meta <= 1'b1; rx_sync <= 1'b1; end
    else begin rx_meta <= rxd; rx_sync <= rx_meta; end
  end

  logic     done;
  rx_char_t chr;

  rxq_deser #(.TICKS(TICKS)) u_deser (
    .clk(clk), .rst(rx_soft), .tick(tick16), .rxd_s(rx_sync),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .done(done), .chr(chr), .brk_edge(brk_change)
  );

  logic            push, pop, full, empty, mv;
  rx_char_t        din, head;
  logic [CNTW-1:0] count, cnt_nx;

  rxq_fifo #(.DEPTH(DEPTH), .W(RXQ_EW), .CNTW(CNTW)) u_fifo (
    .clk(clk), .rst(rx_soft), .push(push), .din(din), .pop(pop),
    .head(head), .full(full), .empty(empty), .count(count)
  );

  rx_char_t hold_q, hold_nx;
  logic     hold_v, hold_v_nx, ovr_set;
  logic     ovr_q, ffull_q, rxrdy_q;
  logic [2:0] sticky_q;

  assign pop    = rd_en && !empty;
  assign mv     = hold_v && !full;
  assign push   = mv || (done && !full);
  assign din    = mv ? hold_q : chr;
  assign cnt_nx = count + CNTW'(push) - CNTW'(pop);

  always_comb begin
    hold_v_nx = hold_v;
    hold_nx   = hold_q;
    ovr_set   = 1'b0;
    if (mv) begin
      if (done) hold_nx = chr;
      else      hold_v_nx = 1'b0;
    end else if (done && full) begin
      if (!hold_v) begin hold_v_nx = 1'b1; hold_nx = chr; end
      else ovr_set = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_soft) begin
      hold_v <= 1'b0; hold_q <= '0; ovr_q <= 1'b0; sticky_q <= '0;
      ffull_q <= 1'b0; rxrdy_q <= 1'b0;
    end else begin
      hold_v  <= hold_v_nx;
      hold_q  <= hold_nx;
      ffull_q <= (cnt_nx == CNTW'(DEPTH)) || hold_v_nx;
      rxrdy_q <= (cnt_nx != '0);
      if (cmd_err_clr) begin
        ovr_q    <= 1'b0;
        sticky_q <= '0;
      end
      if (ovr_set) ovr_q <= 1'b1;
      if (push && !cmd_err_clr) sticky_q <= sticky_q | {din.brk, din.fe, din.pe};
    end
  end

  logic [2:0] flags;
  assign flags   = blk_mode ? sticky_q : (empty ? 3'b000 : {head.brk, head.fe, head.pe});
  assign status  = {flags, ovr_q, 2'b00, ffull_q, rxrdy_q};
  assign rd_data = empty ? 8'h00 : head.data;

  // R7
  ffull_hold_chk: assert property (@(posedge clk) disable iff (rx_soft) ffull_q |-> (full || hold_v));
  // R6
  rdy_nonempty_chk: assert property (@(posedge clk) disable iff (rx_soft) rxrdy_q |-> !empty);
  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rx_soft)
    $rose(ovr_q) |-> $past(done && full && hold_v));
endmodule

// File: tb/tb_rxq_uart_rx.sv
module tb_rxq_uart_rx;
  localparam int CLK_P = 10;
  localparam int TDIV  = 4;
  localparam int BITC  = 16 * TDIV;

  logic clk = 0, rst = 1, tick16 = 0, rxd = 1;
  logic [1:0] char_len = 2'd3;
  logic par_en = 0, par_odd = 0, blk_mode = 0, cmd_err_clr = 0, cmd_rx_reset = 0, rd_en = 0;
  logic [7:0] rd_data, status;
  logic brk_change;

  int checks = 0, errors = 0, brk_cnt = 0;

  logic [10:0] q[$];
  logic [10:0] hold_m;
  bit hold_vm = 0, ovr_m = 0;
  logic [2:0] sticky_m = 0;

  rxq_uart_rx dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .blk_mode(blk_mode), .cmd_err_clr(cmd_err_clr),
    .cmd_rx_reset(cmd_rx_reset), .rd_en(rd_en), .rd_data(rd_data), .status(status),
    .brk_change(brk_change)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      for (int k = 0; k < TDIV; k++) begin
        @(negedge clk);
        tick16 = (k == TDIV-1);
      end
    end
  end

  always @(negedge clk) if (brk_change) brk_cnt++;

  task automatic report_summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report_summary();
    $finish;
  end

  task automatic model_push(input logic [10:0] e);
    if (q.size() < 8) begin q.push_back(e); sticky_m |= e[10:8]; end
    else if (!hold_vm) begin hold_m = e; hold_vm = 1; end
    else ovr_m = 1;
  endtask

  task automatic model_pop();
    void'(q.pop_front());
    if (hold_vm) begin q.push_back(hold_m); sticky_m |= hold_m[10:8]; hold_vm = 0; end
  endtask

  task automatic check_state(input string req);
    logic [2:0] fl;
    logic [7:0] exp_s, exp_d;
    fl = blk_mode ? sticky_m : (q.size() > 0 ? q[0][10:8] : 3'b000);
    exp_s = {fl, ovr_m, 2'b00, (q.size() == 8) || hold_vm, q.size() > 0};
    exp_d = q.size() > 0 ? q[0][7:0] : 8'h00;
    checks++;
    if (status !== exp_s) begin
      errors++;
      $display("FAIL %s status: actual %02h expected %02h", req, status, exp_s);
    end
    checks++;
    if (rd_data !== exp_d) begin
      errors++;
      $display("FAIL %s data: actual %02h expected %02h", req, rd_data, exp_d);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    rxd = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(char_len);
    m = d & 8'((9'h1 << nb) - 1);
    p = (^m) ^ par_odd ^ bad_par;
    drive(0, BITC);
    for (int i = 0; i < nb; i++) drive(m[i], BITC);
    if (par_en) drive(p, BITC);
    if (bad_stop) drive(0, 44);
    drive(1, 2*BITC);
    model_push({1'b0, bad_stop, bad_par && par_en, m});
  endtask

  task automatic cpu_read();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    model_pop();
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check_state("R1");

    // R2 8-bit character
    send_char(8'hA5, 0, 0);
    check_state("R2");
    cpu_read();
    check_state("R6");

    // R2 5-bit character with zero padding
    char_len = 2'd0;
    send_char(8'hFF, 0, 0);
    check_state("R2");
    cpu_read();

    // R3 short glitch is rejected
    drive(0, 3*TDIV);
    drive(1, 3*BITC);
    check_state("R3");

    // R4 per-character flags, even parity, 7 bits
    char_len = 2'd2; par_en = 1; par_odd = 0;
    send_char(8'h35, 0, 0);
    send_char(8'h35, 1, 0);
    par_odd = 1;
    send_char(8'h4C, 0, 1);
    check_state("R4");
    cpu_read(); check_state("R4");
    cpu_read(); check_state("R4");
    cpu_read(); check_state("R4");

    // R5 block mode accumulation
    blk_mode = 1; par_en = 0; char_len = 2'd3;
    send_char(8'h12, 0, 1);
    send_char(8'h34, 0, 0);
    cpu_read(); check_state("R5");
    pulse(cmd_err_clr); sticky_m = 0; ovr_m = 0;
    check_state("R5");
    cpu_read(); check_state("R5");
    blk_mode = 0;

    // R7 R8 R9 fill, hold, overrun
    for (int i = 0; i < 8; i++) send_char(8'(8'h40 + i), 0, 0);
    check_state("R7");
    send_char(8'h58, 0, 0);
    check_state("R7");
    send_char(8'h59, 0, 0);
    check_state("R8");
    cpu_read();
    check_state("R7");
    @(negedge clk);
    check_state("R9");
    for (int i = 0; i < 8; i++) begin
      check_state("R9");
      cpu_read();
    end
    check_state("R6");
    pulse(cmd_err_clr); sticky_m = 0; ovr_m = 0;
    check_state("R8");

    // R10 break
    brk_cnt = 0;
    drive(0, 12*BITC);
    drive(1, 2*BITC);
    model_push(11'h400);
    check_state("R10");
    checks++;
    if (brk_cnt != 2) begin
      errors++;
      $display("FAIL R10 brk_change pulses: actual %0d expected 2", brk_cnt);
    end
    cpu_read();
    check_state("R10");

    // R11 receiver reset
    send_char(8'h77, 0, 1);
    send_char(8'h66, 0, 0);
    pulse(cmd_rx_reset);
    q.delete(); hold_vm = 0; ovr_m = 0; sticky_m = 0;
    check_state("R11");
    send_char(8'h3C, 0, 0);
    check_state("R11");
    cpu_read();
    check_state("R11");

    report_summary();
    $finish;
  end
endmodule